// File: doc/BRIEF.md
# Platform Level Interrupt Controller

This block gathers a parameterised set of external interrupt lines, numbered from 1 upward, and routes them to a small set of target contexts. Each context has one interrupt-request output. Software reaches the block through a single-cycle register bus. On that bus it sets one priority for each source, one enable bank and one threshold for each context, and uses one claim/complete register for each context.

A gateway for each source latches a request as pending. For each context, an arbiter picks the enabled pending source with the highest priority. A source wins only if its priority is strictly above the context's threshold, and on equal priority the lower ID wins. A context takes an interrupt by reading its claim register. That read returns the winning ID and moves the source from pending to in service. Writing the same ID back to the same register completes the interrupt and re-arms the gateway. An instance parameter chooses between level-high and rising-edge sources.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable bit and threshold reads zero, every irq_o bit is low, and a claim read returns 0.
- R2: The priority of source n is a 32-bit register at byte address 4*n. Only bits [PRIO_W-1:0] are stored and the upper bits read zero. Address 0 (source 0) reads zero and ignores writes.
- R3: The enables of context c start at byte address 0x2000 + 0x80*c. Source n is bit (n mod 32) of the word at index (n div 32). Bit 0 of word 0 and bits for IDs above NUM_SRC read zero, and word indices of (NUM_SRC+32)/32 or more are reserved.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. irq_o[c] is high only while some pending source enabled for c has a priority strictly greater than that threshold. A priority of 0 never raises a request, and a threshold of all ones masks every source.
- R5: A read of 0x200004 + 0x1000*c returns, on bus_rdata in the following cycle, the ID of the winning source for c. The highest priority wins, and the lower ID wins on a tie. The read clears that source's pending bit. It returns 0 when no source qualifies.
- R6: In level mode, a high input sets pending. While the source is in service, the input does not set pending again. After completion, an input that is still high becomes pending again, and one that is low does not.
- R7: A write to a context's claim register completes source n only if n is enabled for that context and n is in service. Writes of 0, of IDs above NUM_SRC, or of IDs that fail either condition have no effect.
- R8: In edge mode, a rising edge on an idle source sets pending. Any number of rising edges during service are remembered as one request, which becomes pending at completion. A level held high produces no further request.
- R9: Unaligned addresses, gaps between regions, absent contexts and unused offsets read zero and ignore writes.
- R10: Pending state is shared but selection is per context. A claim by one context removes the source from every context's selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source lines, bit n is source ID n |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The bench builds two instances. The first uses 31 level sources and 2 contexts. It covers priority ties, strict threshold compares, completion filtering, and two contexts sharing one source. The second uses 40 edge sources and 3 contexts. Because 40 sources need a second enable word, it reaches word index 1, the reserved word after it, and the one-deep edge memory of a context other than context 0.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int PRIO_SPAN  = 32'h1000;
    localparam int EN_BASE    = 32'h2000;
    localparam int EN_STRIDE  = 32'h80;
    localparam int CTX_BASE   = 32'h200000;
    localparam int CTX_STRIDE = 32'h1000;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PRIO,
        ACC_ENABLE,
        ACC_THRESH,
        ACC_CLAIM
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [15:0] ctx;
        logic [15:0] idx;
    } acc_t;

    // Map a byte address onto one register class, a context and an index.
    function automatic acc_t map_addr(logic [31:0] a, int nsrc, int nctx, int nwords);
        acc_t        r;
        logic [31:0] off;
        r.kind = ACC_NONE;
        r.ctx  = '0;
        r.idx  = '0;
        off    = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 32'(PRIO_SPAN)) begin
                if (a[11:2] != 10'd0 && 32'(a[11:2]) <= 32'(nsrc)) begin
                    r.kind = ACC_PRIO;
                    r.idx  = 16'(a[11:2]);
                end
            end else if (a >= 32'(EN_BASE) && a < 32'(EN_BASE + EN_STRIDE * nctx)) begin
                off = a - 32'(EN_BASE);
                if (32'(off[6:2]) < 32'(nwords)) begin
                    r.kind = ACC_ENABLE;
                    r.ctx  = off[22:7];
                    r.idx  = 16'(off[6:2]);
                end
            end else if (a >= 32'(CTX_BASE) && a < 32'(CTX_BASE + CTX_STRIDE * nctx)) begin
                off   = a - 32'(CTX_BASE);
                r.ctx = off[27:12];
                if (off[11:0] == 12'h000)
                    r.kind = ACC_THRESH;
                else if (off[11:0] == 12'h004)
                    r.kind = ACC_CLAIM;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic claim,
    input  logic complete,
    output logic pend,
    output logic insvc
);
    logic rise;
    logic mem_q;
    logic n_pend, n_insvc, n_mem;

    generate
        if (EDGE) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= src;
            end
            assign rise = src & ~prev_q;
        end else begin : g_level
            assign rise = src;
        end
    endgenerate

    always_comb begin
        n_pend  = pend;
        n_insvc = insvc;
        n_mem   = mem_q;
        if (claim && pend) begin
            n_pend  = 1'b0;
            n_insvc = 1'b1;
        end
        if (complete && insvc) begin
            n_insvc = 1'b0;
            if (mem_q) begin
                n_pend = 1'b1;
                n_mem  = 1'b0;
            end
        end
        if (rise) begin
            if (!n_pend && !n_insvc)
                n_pend = 1'b1;
            else if (n_insvc && EDGE)
                n_mem = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            insvc <= 1'b0;
            mem_q <= 1'b0;
        end else begin
            pend  <= n_pend;
            insvc <= n_insvc;
            mem_q <= n_mem;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 31,
    parameter int PW   = 3,
    localparam int IDW = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]         pend,
    input  logic [NSRC:1]         en,
    input  logic [NSRC:1][PW-1:0] prio,
    input  logic [PW-1:0]         thr,
    output logic [IDW-1:0]        best_id,
    output logic                  irq
);
    logic [PW-1:0] best_p;

    // Ascending scan with a strict compare: the threshold is the starting
    // bar and an equal priority never displaces a lower ID.
    always_comb begin
        best_id = '0;
        best_p  = thr;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && prio[i] > best_p) begin
                best_p  = prio[i];
                best_id = IDW'(i);
            end
        end
    end

    assign irq = (best_id != '0);
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 31,
    parameter int NUM_CTX   = 2,
    parameter int PRIO_W    = 3,
    parameter bit EDGE_TRIG = 1'b0,
    parameter int ADDR_W    = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC:1]   src_i,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] irq_o
);
    localparam int IDW    = $clog2(NUM_SRC + 1);
    localparam int NWORDS = (NUM_SRC + 32) / 32;

    logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:1] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [NUM_SRC:1]              pend, insvc, claim_vec, cmp_vec;
    logic [NUM_CTX-1:0][IDW-1:0]   best_id;

    acc_t             acc;
    logic             rd_en, wr_en, claim_hit, cmp_hit;
    logic [IDW-1:0]   sel_id;
    logic [NUM_SRC:1] sel_en;
    logic [31:0]      rd_val;

    assign acc       = map_addr(32'(bus_addr), NUM_SRC, NUM_CTX, NWORDS);
    assign rd_en     = bus_req & ~bus_we;
    assign wr_en     = bus_req & bus_we;
    assign claim_hit = rd_en && (acc.kind == ACC_CLAIM);
    assign cmp_hit   = wr_en && (acc.kind == ACC_CLAIM);

    always_comb begin
        sel_id = '0;
        sel_en = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (acc.ctx == 16'(c)) begin
                sel_id = best_id[c];
                sel_en = en_q[c];
            end
        end
    end

    always_comb begin
        for (int i = 1; i <= NUM_SRC; i++) begin
            claim_vec[i] = claim_hit && (sel_id == IDW'(i));
            cmp_vec[i]   = cmp_hit && sel_en[i] && (bus_wdata == 32'(i));
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (acc.kind)
            ACC_PRIO: begin
                for (int i = 1; i <= NUM_SRC; i++)
                    if (acc.idx == 16'(i)) rd_val = 32'(prio_q[i]);
            end
            ACC_ENABLE: begin
                for (int c = 0; c < NUM_CTX; c++)
                    for (int i = 1; i <= NUM_SRC; i++)
                        if (acc.ctx == 16'(c) && acc.idx == 16'(i / 32))
                            rd_val[i % 32] = en_q[c][i];
            end
            ACC_THRESH: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (acc.ctx == 16'(c)) rd_val = 32'(thr_q[c]);
            end
            ACC_CLAIM: rd_val = 32'(sel_id);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q    <= '0;
            en_q      <= '0;
            thr_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (rd_en) bus_rdata <= rd_val;
            if (wr_en) begin
                for (int i = 1; i <= NUM_SRC; i++)
                    if (acc.kind == ACC_PRIO && acc.idx == 16'(i))
                        prio_q[i] <= bus_wdata[PRIO_W-1:0];
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (acc.kind == ACC_THRESH && acc.ctx == 16'(c))
                        thr_q[c] <= bus_wdata[PRIO_W-1:0];
                    for (int i = 1; i <= NUM_SRC; i++)
                        if (acc.kind == ACC_ENABLE && acc.ctx == 16'(c) && acc.idx == 16'(i / 32))
                            en_q[c][i] <= bus_wdata[i % 32];
                end
            end
        end
    end

    generate
        for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
            irq_gateway #(.EDGE(EDGE_TRIG)) u_gw (
                .clk      (clk),
                .rst      (rst),
                .src      (src_i[i]),
                .claim    (claim_vec[i]),
                .complete (cmp_vec[i]),
                .pend     (pend[i]),
                .insvc    (insvc[i])
            );
        end
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            irq_arbiter #(.NSRC(NUM_SRC), .PW(PRIO_W)) u_arb (
                .pend    (pend),
                .en      (en_q[c]),
                .prio    (prio_q),
                .thr     (thr_q[c]),
                .best_id (best_id[c]),
                .irq     (irq_o[c])
            );
        end
    endgenerate
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       claim_hit,
    input logic [31:0]                bus_rdata,
    input logic [NUM_CTX-1:0]         irq_o,
    input logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q,
    input logic [NUM_SRC:1]           pend,
    input logic [NUM_SRC:1]           insvc,
    input logic [NUM_SRC:1]           claim_vec
);
    // R5
    claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (|claim_vec) |=> ((pend & $past(claim_vec)) == '0));

    // R5
    claim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec));

    // R5
    claim_range_chk: assert property (@(posedge clk) disable iff (rst)
        claim_hit |=> (bus_rdata <= 32'(NUM_SRC)));

    // R6
    pend_svc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend & insvc) == '0));

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr
            // R4
            thr_mask_chk: assert property (@(posedge clk) disable iff (rst)
                (thr_q[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]);
        end
    endgenerate
endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .claim_hit (claim_hit),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .thr_q     (thr_q),
    .pend      (pend),
    .insvc     (insvc),
    .claim_vec (claim_vec)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req0 = 0, we0 = 0, req1 = 0, we1 = 0;
    logic [23:0] addr0 = '0, addr1 = '0;
    logic [31:0] wd0 = '0, wd1 = '0, rd0, rd1;
    logic [31:1] src0 = '0;
    logic [40:1] src1 = '0;
    logic [1:0]  irq0;
    logic [2:0]  irq1;

    irq_router #(.NUM_SRC(31), .NUM_CTX(2), .EDGE_TRIG(1'b0)) u0 (
        .clk(clk), .rst(rst), .src_i(src0), .bus_req(req0), .bus_we(we0),
        .bus_addr(addr0), .bus_wdata(wd0), .bus_rdata(rd0), .irq_o(irq0));

    irq_router #(.NUM_SRC(40), .NUM_CTX(3), .EDGE_TRIG(1'b1)) u1 (
        .clk(clk), .rst(rst), .src_i(src1), .bus_req(req1), .bus_we(we1),
        .bus_addr(addr1), .bus_wdata(wd1), .bus_rdata(rd1), .irq_o(irq1));

    int total = 0;
    int fails = 0;

    typedef struct {
        int          d;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    item_t cur;

    function automatic logic [23:0] a_prio(int id);      return 24'(4 * id); endfunction
    function automatic logic [23:0] a_en(int c, int w);  return 24'(32'h2000 + 32'h80 * c + 4 * w); endfunction
    function automatic logic [23:0] a_thr(int c);        return 24'(32'h200000 + 32'h1000 * c); endfunction
    function automatic logic [23:0] a_clm(int c);        return 24'(32'h200004 + 32'h1000 * c); endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int d, input logic [23:0] a, input logic [31:0] v);
        if (d == 0) begin req0 = 1; we0 = 1; addr0 = a; wd0 = v; end
        else        begin req1 = 1; we1 = 1; addr1 = a; wd1 = v; end
        @(negedge clk);
        req0 = 0; we0 = 0; req1 = 0; we1 = 0;
    endtask

    task automatic rd(input int d, input logic [23:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.d = d; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        if (d == 0) begin req0 = 1; we0 = 0; addr0 = a; end
        else        begin req1 = 1; we1 = 0; addr1 = a; end
        @(negedge clk);
        req0 = 0; req1 = 0;
    endtask

    // Monitor: note which instance read at the edge, compare half a cycle later.
    logic due0 = 0, due1 = 0;
    always @(posedge clk) begin
        due0 <= req0 & ~we0;
        due1 <= req1 & ~we1;
    end
    always @(negedge clk) begin
        if (due0 || due1) begin
            if (sbq.size() == 0) begin
                check(32'hdead, 32'h0, "scoreboard underflow");
            end else begin
                cur = sbq.pop_front();
                check(cur.d == 0 ? rd0 : rd1, cur.exp, cur.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        check(32'(irq0), 0, "R1 irq0 after reset");
        check(32'(irq1), 0, "R1 irq1 after reset");
        rd(0, a_prio(5), 0, "R1 prio reset");
        rd(0, a_en(0, 0), 0, "R1 enable reset");
        rd(0, a_thr(1), 0, "R1 threshold reset");
        rd(0, a_clm(0), 0, "R1 empty claim");

        // R2 priority field width, source 0
        wr(0, a_prio(5), 32'hFFFF_FFFF);
        rd(0, a_prio(5), 7, "R2 prio width");
        wr(0, a_prio(0), 7);
        rd(0, a_prio(0), 0, "R2 source 0 prio");

        // R3 enable bit layout
        wr(0, a_en(0, 0), 32'hFFFF_FFFF);
        rd(0, a_en(0, 0), 32'hFFFF_FFFE, "R3 bit0 reads zero");
        wr(0, a_en(0, 0), 32'h0000_0228);
        rd(0, a_en(0, 0), 32'h0000_0228, "R3 enable readback");

        // R4 strict threshold
        wr(0, a_prio(3), 2);
        wr(0, a_prio(5), 2);
        wr(0, a_thr(0), 2);
        src0[3] = 1'b1;
        tick();
        check(32'(irq0[0]), 0, "R4 equal to threshold");
        wr(0, a_thr(0), 1);
        check(32'(irq0[0]), 1, "R4 above threshold");

        // R5 tie order and R6 in-service blocking, R4 priority 0
        src0[5] = 1'b1;
        src0[9] = 1'b1;
        tick();
        rd(0, a_clm(0), 3, "R5 tie lower ID");
        rd(0, a_clm(0), 5, "R5 second claim");
        rd(0, a_clm(0), 0, "R5 nothing eligible (prio 0 source)");
        check(32'(irq0[0]), 0, "R6 held level blocked in service");

        // R7 filtered completions
        wr(0, a_clm(1), 3);
        wr(0, a_clm(0), 0);
        wr(0, a_clm(0), 40);
        tick();
        check(32'(irq0[0]), 0, "R7 ignored completions");
        wr(0, a_clm(0), 3);
        tick();
        check(32'(irq0[0]), 1, "R6 re-pend after completion");
        rd(0, a_clm(0), 3, "R6 reclaim");
        src0[3] = 1'b0;
        wr(0, a_clm(0), 3);
        tick();
        tick();
        check(32'(irq0[0]), 0, "R6 low input stays idle");

        // R10 two contexts share one source
        wr(0, a_en(1, 0), 32'h20);
        wr(0, a_clm(0), 5);
        tick();
        check(32'(irq0), 3, "R10 both contexts see source 5");
        rd(0, a_clm(1), 5, "R10 claim by context 1");
        check(32'(irq0), 0, "R10 claim removes from both");
        wr(0, a_clm(1), 5);
        tick();
        wr(0, a_thr(1), 7);
        check(32'(irq0), 1, "R4 threshold 7 masks context 1");

        // R9 reserved space
        rd(0, 24'h001000, 0, "R9 gap read");
        rd(0, a_en(2, 0), 0, "R9 absent context enable");
        wr(0, 24'h200008, 5);
        rd(0, 24'h200008, 0, "R9 unused offset");
        wr(0, 24'h000016, 3);
        rd(0, a_prio(5), 2, "R9 unaligned write ignored");

        // R3 second enable word, reserved third word (edge instance)
        wr(1, a_en(2, 1), 32'hFFFF_FFFF);
        rd(1, a_en(2, 1), 32'h0000_01FF, "R3 word1 upper IDs read zero");
        wr(1, a_en(2, 1), 32'h0000_0002);
        rd(1, a_en(2, 1), 32'h0000_0002, "R3 ID 33 at word1 bit1");
        rd(1, a_en(2, 2), 0, "R3 reserved word");

        // R8 edge gateway
        wr(1, a_prio(33), 4);
        src1[33] = 1'b1;
        tick();
        check(32'(irq1), 4, "R8 rising edge pends");
        rd(1, a_clm(2), 33, "R8 claim edge source");
        check(32'(irq1), 0, "R8 in service");
        src1[33] = 1'b0; tick();
        src1[33] = 1'b1; tick();
        src1[33] = 1'b0; tick();
        src1[33] = 1'b1; tick();
        check(32'(irq1), 0, "R8 edges in service held back");
        wr(1, a_clm(2), 33);
        check(32'(irq1), 4, "R8 remembered edge after completion");
        rd(1, a_clm(2), 33, "R8 reclaim remembered");
        wr(1, a_clm(2), 33);
        tick();
        tick();
        check(32'(irq1), 0, "R8 only one remembered, level ignored");

        tick();
        tick();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule